// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster framing for a display pipeline. It emits horizontal and vertical sync pulses, a data-enable strobe and the current pixel and line positions. The geometry is not described as porches. Each axis is given as four numbers: a total length, a blanking length, a delay from the end of active video to the start of sync, and a sync width. The active width on each axis is the total minus the blanking. Horizontal values arrive as low and high byte pairs. The vertical total is also a byte pair. The other three vertical values are single bytes.

Each sync output has its own polarity select. An interlace enable splits each frame into two fields: an even field with the larger half of the lines and an odd field with the smaller half. On the odd field, vsync is shifted by half a line. Parameter inputs are plain levels. The block copies them into a working set only when a field begins, and at the first clock after reset. Writes made partway through a field therefore never distort the field in progress. There is no streaming interface: every pin is a plain control or status level.

Top module: `vtg_timing_gen`

## Requirements
- R1: While rst_n is low, hcount, vcount and field are 0 and de, hsync and vsync are low.
- R2: hcount counts from 0 up to htotal-1 and then returns to 0. htotal is {htot_hi, htot_lo}. vcount steps up by one each time hcount returns to 0, and returns to 0 after the last line of the current field.
- R3: de is high exactly when hcount < htotal-hblank and vcount < field_lines-vblank. hblank is {hblank_hi, hblank_lo}. field_lines is the line count of the current field: vtotal when progressive, as defined in R7 when interlaced.
- R4: The horizontal sync is active for hcount in [A+hdelay, A+hdelay+hwidth), where A = htotal-hblank. hdelay and hwidth are each a high:low byte pair.
- R5: With interlace off, or in the even field, vertical sync is active on whole lines with vcount in [V+vdelay, V+vdelay+vwidth), where V = field_lines-vblank.
- R6: A polarity input of 1 makes its sync output high while active and low otherwise. A polarity input of 0 gives the inverse. The two selects are independent.
- R7: With interlace_en set, field toggles at every field start. The even field (field=0) has ceil(vtotal/2) lines and the odd field (field=1) has floor(vtotal/2) lines.
- R8: In the odd field, the vertical sync window of R5 starts at hcount = floor(htotal/2) of its first line and ends at the same hcount of its end line.
- R9: Parameter and mode inputs are captured at the first clock after reset and on the clock where the last pixel of a field ends. Changes at any other time have no effect until that point.
- R10: With interlace disabled for the field in progress, field stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htot_lo | input | 8 | Horizontal total, low byte |
| htot_hi | input | 8 | Horizontal total, high byte |
| hblank_lo | input | 8 | Horizontal blanking length, low byte |
| hblank_hi | input | 8 | Horizontal blanking length, high byte |
| hdelay_lo | input | 8 | Active-end to hsync-start delay, low byte |
| hdelay_hi | input | 8 | Active-end to hsync-start delay, high byte |
| hwidth_lo | input | 8 | Hsync width, low byte |
| hwidth_hi | input | 8 | Hsync width, high byte |
| vtot_lo | input | 8 | Vertical total, low byte |
| vtot_hi | input | 8 | Vertical total, high byte |
| vblank | input | 8 | Vertical blanking lines per field |
| vdelay | input | 8 | Active-end to vsync-start delay in lines |
| vwidth | input | 8 | Vsync width in lines |
| hsync_pol | input | 1 | 1 = hsync active-high, 0 = active-low |
| vsync_pol | input | 1 | 1 = vsync active-high, 0 = active-low |
| interlace_en | input | 1 | 1 = two alternating fields per frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | Current field, 0 = even |
| hcount | output | 16 | Pixel position in the line |
| vcount | output | 16 | Line position in the field |

## Verification
Position counters change on the rising edge. de, hsync, vsync and field are decoded from those counters in the same cycle, with no extra register stage. Every output is therefore due in the cycle that follows the edge that moved the counters. The bench keeps its own position and working-set model and advances it on the rising edge, taking a parameter snapshot whenever the model reaches a field boundary or leaves reset. It compares all outputs on the falling edge. A parameter write made partway through a field is therefore held against the old geometry until exactly the first cycle at position (0,0).

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef struct packed {
    logic [CNT_W-1:0]  htot;
    logic [CNT_W-1:0]  hblank;
    logic [CNT_W-1:0]  hdelay;
    logic [CNT_W-1:0]  hwidth;
    logic [CNT_W-1:0]  vtot;
    logic [BYTE_W-1:0] vblank;
    logic [BYTE_W-1:0] vdelay;
    logic [BYTE_W-1:0] vwidth;
    logic              hpol;
    logic              vpol;
    logic              ilace;
  } timing_t;

  localparam timing_t CFG_RST = '{'0, '0, '0, '0, '0, '0, '0, '0, 1'b1, 1'b1, 1'b0};
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  timing_t nxt,
  output timing_t cur
);
  // Working copy of the geometry; only replaced on a field boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= CFG_RST;
    else if (load) cur <= nxt;
  end
endmodule

// File: rtl/vtg_hgen.sv
module vtg_hgen
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] htot,
  input  logic [CNT_W-1:0] hblank,
  input  logic [CNT_W-1:0] hdelay,
  input  logic [CNT_W-1:0] hwidth,
  output logic [CNT_W-1:0] hcount,
  output logic             h_last,
  output logic             h_active,
  output logic             h_sync_act,
  output logic             h_second_half
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hact, hs_beg, hs_end;

  always_comb begin
    hact          = htot - hblank;
    hs_beg        = hact + hdelay;
    hs_end        = hs_beg + hwidth;
    h_last        = (hcount == htot - ONE);
    h_active      = (hcount < hact);
    h_sync_act    = (hcount >= hs_beg) && (hcount < hs_end);
    h_second_half = (hcount >= (htot >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcount <= '0;
    else if (!run)   hcount <= '0;
    else if (h_last) hcount <= '0;
    else             hcount <= hcount + ONE;
  end
endmodule

// File: rtl/vtg_vgen.sv
module vtg_vgen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              h_last,
  input  logic              h_second_half,
  input  logic              ilace_next,
  input  logic [CNT_W-1:0]  vtot,
  input  logic [BYTE_W-1:0] vblank,
  input  logic [BYTE_W-1:0] vdelay,
  input  logic [BYTE_W-1:0] vwidth,
  input  logic              ilace,
  output logic [CNT_W-1:0]  vcount,
  output logic              field,
  output logic              v_active,
  output logic              v_sync_act,
  output logic              field_wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam int PAD = CNT_W - BYTE_W;

  logic [CNT_W:0]   vtot_up;
  logic [CNT_W-1:0] flen, vact, vs_beg, vs_end;
  logic             v_last, after_beg, before_end;

  always_comb begin
    vtot_up = {1'b0, vtot} + {{CNT_W{1'b0}}, 1'b1};
    if (ilace) flen = field ? (vtot >> 1) : vtot_up[CNT_W:1];
    else       flen = vtot;
    vact     = flen - {{PAD{1'b0}}, vblank};
    vs_beg   = vact + {{PAD{1'b0}}, vdelay};
    vs_end   = vs_beg + {{PAD{1'b0}}, vwidth};
    v_last   = (vcount == flen - ONE);
    v_active = (vcount < vact);
    field_wrap = run && h_last && v_last;
    if (ilace && field) begin
      // odd field: window edges sit at mid-line
      after_beg  = (vcount > vs_beg) || ((vcount == vs_beg) && h_second_half);
      before_end = (vcount < vs_end) || ((vcount == vs_end) && !h_second_half);
    end else begin
      after_beg  = (vcount >= vs_beg);
      before_end = (vcount < vs_end);
    end
    v_sync_act = after_beg && before_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcount <= '0;
      field  <= 1'b0;
    end else if (!run) begin
      vcount <= '0;
      field  <= 1'b0;
    end else if (h_last) begin
      if (v_last) begin
        vcount <= '0;
        field  <= ilace_next & ~field;
      end else begin
        vcount <= vcount + ONE;
      end
    end
  end
endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] htot_lo,
  input  logic [BYTE_W-1:0] htot_hi,
  input  logic [BYTE_W-1:0] hblank_lo,
  input  logic [BYTE_W-1:0] hblank_hi,
  input  logic [BYTE_W-1:0] hdelay_lo,
  input  logic [BYTE_W-1:0] hdelay_hi,
  input  logic [BYTE_W-1:0] hwidth_lo,
  input  logic [BYTE_W-1:0] hwidth_hi,
  input  logic [BYTE_W-1:0] vtot_lo,
  input  logic [BYTE_W-1:0] vtot_hi,
  input  logic [BYTE_W-1:0] vblank,
  input  logic [BYTE_W-1:0] vdelay,
  input  logic [BYTE_W-1:0] vwidth,
  input  logic              hsync_pol,
  input  logic              vsync_pol,
  input  logic              interlace_en,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              field,
  output logic [CNT_W-1:0]  hcount,
  output logic [CNT_W-1:0]  vcount
);
  localparam int NSYNC = 2;

  timing_t cfg_in, cfg_q;
  logic    run, load, field_wrap;
  logic    h_last, h_active, h_sync_act, h_second_half;
  logic    v_active, v_sync_act;
  logic [NSYNC-1:0] sync_act, sync_pol, sync_out;

  always_comb begin
    cfg_in.htot   = {htot_hi, htot_lo};
    cfg_in.hblank = {hblank_hi, hblank_lo};
    cfg_in.hdelay = {hdelay_hi, hdelay_lo};
    cfg_in.hwidth = {hwidth_hi, hwidth_lo};
    cfg_in.vtot   = {vtot_hi, vtot_lo};
    cfg_in.vblank = vblank;
    cfg_in.vdelay = vdelay;
    cfg_in.vwidth = vwidth;
    cfg_in.hpol   = hsync_pol;
    cfg_in.vpol   = vsync_pol;
    cfg_in.ilace  = interlace_en;
  end

  // run rises on the first edge after reset; that edge also takes the snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  assign load = !run || field_wrap;

  vtg_shadow u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .nxt   (cfg_in),
    .cur   (cfg_q)
  );

  vtg_hgen u_hgen (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .htot          (cfg_q.htot),
    .hblank        (cfg_q.hblank),
    .hdelay        (cfg_q.hdelay),
    .hwidth        (cfg_q.hwidth),
    .hcount        (hcount),
    .h_last        (h_last),
    .h_active      (h_active),
    .h_sync_act    (h_sync_act),
    .h_second_half (h_second_half)
  );

  vtg_vgen u_vgen (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .h_last        (h_last),
    .h_second_half (h_second_half),
    .ilace_next    (interlace_en),
    .vtot          (cfg_q.vtot),
    .vblank        (cfg_q.vblank),
    .vdelay        (cfg_q.vdelay),
    .vwidth        (cfg_q.vwidth),
    .ilace         (cfg_q.ilace),
    .vcount        (vcount),
    .field         (field),
    .v_active      (v_active),
    .v_sync_act    (v_sync_act),
    .field_wrap    (field_wrap)
  );

  assign sync_act = {v_sync_act, h_sync_act};
  assign sync_pol = {cfg_q.vpol, cfg_q.hpol};

  for (genvar g = 0; g < NSYNC; g++) begin : g_pol
    assign sync_out[g] = sync_pol[g] ? (run && sync_act[g]) : !(run && sync_act[g]);
  end

  assign hsync = sync_out[0];
  assign vsync = sync_out[1];
  assign de    = run && h_active && v_active;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] hcount,
  input logic [CNT_W-1:0] vcount,
  input logic             field,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input timing_t          cfg
);
  a_r2_hcount_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != '0) |-> (hcount == $past(hcount) + 1'b1));

  a_r4_hsync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync == cfg.hpol) |-> !de);

  a_r5_vsync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync == cfg.vpol) |-> !de);

  a_r7_field_moves_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (hcount == '0 && vcount == '0));

  a_r9_snapshot_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !(hcount == '0 && vcount == '0) |-> $stable(cfg));

  a_r10_progressive_even: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.ilace |-> !field);
endmodule

bind vtg_timing_gen vtg_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hcount (hcount),
  .vcount (vcount),
  .field  (field),
  .de     (de),
  .hsync  (hsync),
  .vsync  (vsync),
  .cfg    (cfg_q)
);

// File: tb/tb_vtg_timing_gen.sv
module tb_vtg_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] htot_lo, htot_hi, hblank_lo, hblank_hi, hdelay_lo, hdelay_hi;
  logic [7:0] hwidth_lo, hwidth_hi, vtot_lo, vtot_hi, vblank, vdelay, vwidth;
  logic hsync_pol, vsync_pol, interlace_en;
  logic hsync, vsync, de, field;
  logic [15:0] hcount, vcount;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // driven configuration
  int i_ht, i_hb, i_hd, i_hw, i_vt, i_vb, i_vd, i_vw, i_hp, i_vp, i_il;
  // model snapshot and position
  int s_ht, s_hb, s_hd, s_hw, s_vt, s_vb, s_vd, s_vw, s_hp, s_vp, s_il;
  int m_run, m_h, m_v, m_f;

  always #2 clk = ~clk;

  vtg_timing_gen dut (
    .clk(clk), .rst_n(rst_n),
    .htot_lo(htot_lo), .htot_hi(htot_hi), .hblank_lo(hblank_lo), .hblank_hi(hblank_hi),
    .hdelay_lo(hdelay_lo), .hdelay_hi(hdelay_hi), .hwidth_lo(hwidth_lo), .hwidth_hi(hwidth_hi),
    .vtot_lo(vtot_lo), .vtot_hi(vtot_hi), .vblank(vblank), .vdelay(vdelay), .vwidth(vwidth),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .interlace_en(interlace_en),
    .hsync(hsync), .vsync(vsync), .de(de), .field(field), .hcount(hcount), .vcount(vcount)
  );

  task automatic set_cfg(int ht, int hb, int hd, int hw, int vt, int vb, int vd, int vw,
                         int hp, int vp, int il);
    i_ht = ht; i_hb = hb; i_hd = hd; i_hw = hw; i_vt = vt; i_vb = vb; i_vd = vd; i_vw = vw;
    i_hp = hp; i_vp = vp; i_il = il;
    htot_lo = ht[7:0];   htot_hi = ht[15:8];
    hblank_lo = hb[7:0]; hblank_hi = hb[15:8];
    hdelay_lo = hd[7:0]; hdelay_hi = hd[15:8];
    hwidth_lo = hw[7:0]; hwidth_hi = hw[15:8];
    vtot_lo = vt[7:0];   vtot_hi = vt[15:8];
    vblank = vb[7:0]; vdelay = vd[7:0]; vwidth = vw[7:0];
    hsync_pol = hp[0]; vsync_pol = vp[0]; interlace_en = il[0];
  endtask

  function automatic int lines_now();
    if (s_il != 0) return (m_f != 0) ? s_vt / 2 : (s_vt + 1) / 2;
    return s_vt;
  endfunction

  task automatic snap();
    s_ht = i_ht; s_hb = i_hb; s_hd = i_hd; s_hw = i_hw; s_vt = i_vt; s_vb = i_vb;
    s_vd = i_vd; s_vw = i_vw; s_hp = i_hp; s_vp = i_vp; s_il = i_il;
  endtask

  // reference position model, advanced on the same edge as the design
  always @(posedge clk) begin
    int fl;
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_f = 0;
      s_ht = 0; s_hb = 0; s_hd = 0; s_hw = 0; s_vt = 0; s_vb = 0; s_vd = 0; s_vw = 0;
      s_hp = 1; s_vp = 1; s_il = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_h = 0; m_v = 0; m_f = 0;
      snap();
    end else begin
      fl = lines_now();
      if (m_h == s_ht - 1) begin
        m_h = 0;
        if (m_v == fl - 1) begin
          m_v = 0;
          m_f = (i_il != 0) ? 1 - m_f : 0;
          snap();
        end else m_v++;
      end else m_h++;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic compare();
    int hact, hss, hse, fl, vact, vss, vse, half, pos, lo, hi;
    int e_de, e_hs, e_vs;
    bit dirty;
    string vtag, ftag;
    if (m_run == 0) begin
      chk("R1 hcount in reset", hcount, 0);
      chk("R1 vcount in reset", vcount, 0);
      chk("R1 field in reset", field, 0);
      chk("R1 de in reset", de, 0);
      chk("R1 hsync in reset", hsync, 0);
      chk("R1 vsync in reset", vsync, 0);
      return;
    end
    hact = s_ht - s_hb; hss = hact + s_hd; hse = hss + s_hw;
    fl = lines_now(); vact = fl - s_vb; vss = vact + s_vd; vse = vss + s_vw;
    half = s_ht / 2;
    pos = m_v * s_ht + m_h;
    if (s_il != 0 && m_f != 0) begin
      lo = vss * s_ht + half; hi = vse * s_ht + half;
    end else begin
      lo = vss * s_ht; hi = vse * s_ht;
    end
    e_de = (m_h < hact && m_v < vact) ? 1 : 0;
    e_hs = (m_h >= hss && m_h < hse) ? 1 : 0;
    e_vs = (pos >= lo && pos < hi) ? 1 : 0;
    if (s_hp == 0) e_hs = 1 - e_hs;
    if (s_vp == 0) e_vs = 1 - e_vs;
    vtag = (s_il != 0 && m_f != 0) ? "R8 R6 vsync odd field" : "R5 R6 vsync";
    ftag = (s_il != 0) ? "R7 field" : "R10 field";
    chk("R2 hcount", hcount, m_h);
    chk("R2 vcount", vcount, m_v);
    chk("R3 de", de, e_de);
    chk("R4 R6 hsync", hsync, e_hs);
    chk(vtag, vsync, e_vs);
    chk(ftag, field, m_f);
    dirty = (i_ht != s_ht) || (i_hb != s_hb) || (i_vt != s_vt) || (i_il != s_il) ||
            (i_hp != s_hp) || (i_vp != s_vp);
    if (dirty) chk("R9 position under pending update", hcount, m_h);
  endtask

  task automatic run_cycles(int n);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    set_cfg(20, 6, 2, 3, 12, 4, 1, 2, 1, 1, 0);
    rst_n = 1'b0;
    run_cycles(4);
    rst_n = 1'b1;
    run_cycles(500);
    // mid-field rewrite: new geometry and active-low syncs
    set_cfg(24, 8, 1, 4, 10, 3, 2, 3, 0, 0, 0);
    run_cycles(700);
    // interlace, odd total: 7-line and 6-line fields
    set_cfg(18, 4, 3, 2, 13, 3, 1, 1, 1, 0, 1);
    run_cycles(900);
    // interlace, even total, odd line length, zero delays
    set_cfg(17, 5, 0, 4, 12, 2, 0, 1, 0, 1, 1);
    run_cycles(700);
    // reset in the middle of a field
    @(negedge clk);
    #1 rst_n = 1'b0;
    run_cycles(3);
    // high bytes in use on the horizontal axis
    set_cfg(300, 272, 261, 11, 6, 2, 1, 1, 1, 1, 0);
    rst_n = 1'b1;
    run_cycles(2100);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule